// File: doc/BRIEF.md
# SMBus Charger Settings Target with Host Watchdog

This block is the digital front end of a battery charger controller. It acts as a target on a two-wire SMBus and takes write-word and read-word transfers aimed at five 16-bit charger setting registers. The registers are option, charge current, maximum charge voltage, minimum system voltage and input current. Their contents drive outputs that the analog part of the chip uses. The SCL and SDA pins are oversampled with the system clock. The target pulls SDA low through an open-drain enable.

Two timers count a 1 ms tick input. A bus timeout abandons a transfer when SCL stays low too long, and the target then lets go of SDA. A host watchdog drops charging when the host stops refreshing the charge settings. The watchdog period is chosen by two option bits. When it expires, the charge current register is cleared and an expired flag is raised. Because both timers count ticks, a bench can scale time down by pulsing the tick input directly.

Top module: `smbc_charger_regs`

## Requirements
- R1: After reset the registers hold option 0x6140, charge current 0x0000, maximum voltage 0x34C0, minimum system voltage 0x2400 and input current 0x1000. SDA is released, charge enable is 0 and the expired flag is 0.
- R2: A write-word to 7-bit address 0x09 is acknowledged on all four bytes. The byte order is address+W, command, data low, data high. The addressed register takes the new value. The command codes are 0x12 option, 0x14 charge current, 0x15 maximum voltage, 0x3E minimum system voltage and 0x3F input current.
- R3: A read-word sends address+W and the command, then a repeated START and address+R. The target returns the low byte and then the high byte. If the host NACKs the low byte, the target stops driving for the rest of the transfer.
- R4: A transfer to any other address is not acknowledged and changes no register.
- R5: A write to an unknown command code is acknowledged on every byte and changes no register. A read of an unknown code returns 0x0000.
- R6: The option register stores and reads back all 16 bits. This includes the switching-frequency field in bits [9:8].
- R7: When SCL has been low for BUS_TOUT_MS ticks, the target releases SDA on the next clock and returns to idle. A later transfer then works normally.
- R8: Option bits [14:13] set the watchdog limit: 01 gives WD_UNIT_MS, 10 gives 2×WD_UNIT_MS and 11 gives 4×WD_UNIT_MS, each plus WD_DEG_MS ticks of deglitch. Expiry happens on the tick that reaches the limit, counted from the last refresh.
- R9: On expiry the expired flag is set, the charge current register becomes 0x0000 and charge enable falls.
- R10: Only a write to the charge current or maximum voltage register restarts the watchdog count and clears the expired flag. Writes to the other registers leave the count running.
- R11: Option bits [14:13] = 00 disable the watchdog. No number of ticks causes an expiry.
- R12: Charge enable is 1 exactly when the charge current register is nonzero and the watchdog has not expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| scl_i | input | 1 | SMBus clock pin sample |
| sda_i | input | 1 | SMBus data pin sample |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| opt_o | output | 16 | Option register |
| chg_cur_o | output | 16 | Charge current register |
| chg_volt_o | output | 16 | Maximum charge voltage register |
| min_sys_o | output | 16 | Minimum system voltage register |
| in_cur_o | output | 16 | Input current register |
| charge_en_o | output | 1 | Charging allowed |
| wd_expired_o | output | 1 | Host watchdog has expired |

## Verification
The pins pass through a two-stage synchronizer and an edge register, so the engine sees an SCL edge three clocks after the pin changes. The SDA drive changes one clock after that. The bench therefore samples SDA at the end of each SCL high phase, which comes many clocks after the target's last change. Register outputs are checked only after the STOP, well after the one-clock write update. The watchdog flag and the cleared charge current appear one clock after the deciding tick cycle, and the released SDA appears one clock after the timeout tick. The bench pulses ticks itself and samples two clock falls after the last tick, so each expected value is the count of ticks it has applied.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
  localparam logic [7:0] CMD_OPT  = 8'h12;
  localparam logic [7:0] CMD_ICHG = 8'h14;
  localparam logic [7:0] CMD_VMAX = 8'h15;
  localparam logic [7:0] CMD_VMIN = 8'h3E;
  localparam logic [7:0] CMD_IIN  = 8'h3F;

  localparam logic [15:0] RST_OPT  = 16'h6140;
  localparam logic [15:0] RST_ICHG = 16'h0000;
  localparam logic [15:0] RST_VMAX = 16'h34C0;
  localparam logic [15:0] RST_VMIN = 16'h2400;
  localparam logic [15:0] RST_IIN  = 16'h1000;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_WLO, PH_WHI, PH_RLO, PH_RHI, PH_SKIP
  } phase_t;
endpackage

// File: rtl/smbc_busif.sv
module smbc_busif #(
  parameter int SYNC_STAGES = 2,
  parameter int TOUT_MS     = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p,
  output logic tout_p
);
  localparam int TW = $clog2(TOUT_MS + 1);

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_s, scl_d, sda_d;
  logic [TW-1:0] lo_cnt, lo_cnt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q[0] <= scl_i;
      sda_q[0] <= sda_i;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_q[g] <= 1'b1;
        sda_q[g] <= 1'b1;
      end else begin
        scl_q[g] <= scl_q[g-1];
        sda_q[g] <= sda_q[g-1];
      end
    end
  end

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      lo_cnt <= '0;
    end else begin
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      lo_cnt <= lo_cnt_n;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

  always_comb begin
    lo_cnt_n = lo_cnt;
    tout_p   = 1'b0;
    if (scl_s) begin
      lo_cnt_n = '0;
    end else if (tick && (lo_cnt != TW'(TOUT_MS))) begin
      lo_cnt_n = lo_cnt + 1'b1;
      tout_p   = (lo_cnt == TW'(TOUT_MS - 1));
    end
  end
endmodule

// File: rtl/smbc_engine.sv
module smbc_engine
  import smbc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_p,
  input  logic        stop_p,
  input  logic        tout_p,
  input  logic        sda_s,
  input  logic [15:0] rd_data,
  output logic [7:0]  cmd,
  output logic        wr_en,
  output logic [15:0] wr_data,
  output logic        sda_oe
);
  phase_t ph, ph_n;
  logic in_ack, ack_n, rw_q, rw_n, mnack, nack_n, drv_n;
  logic [3:0] bitcnt, bc_n;
  logic [7:0] shreg, sh_n, txsr, tx_n, lo_q, lo_n, cmd_n;
  logic reading;

  assign reading = (ph == PH_RLO) || (ph == PH_RHI);

  always_comb begin
    ph_n = ph; ack_n = in_ack; bc_n = bitcnt; sh_n = shreg; tx_n = txsr;
    lo_n = lo_q; cmd_n = cmd; drv_n = sda_oe; nack_n = mnack; rw_n = rw_q;
    wr_en = 1'b0;
    if (tout_p || stop_p) begin
      ph_n = PH_IDLE; ack_n = 1'b0; drv_n = 1'b0;
    end else if (start_p) begin
      ph_n = PH_ADDR; ack_n = 1'b0; bc_n = '0; drv_n = 1'b0;
    end else if (ph != PH_IDLE && ph != PH_SKIP) begin
      if (scl_rise) begin
        if (in_ack) nack_n = sda_s;
        else begin
          bc_n = bitcnt + 1'b1;
          if (!reading) sh_n = {shreg[6:0], sda_s};
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          ack_n = 1'b0; bc_n = '0; drv_n = 1'b0;
          case (ph)
            PH_ADDR: if (rw_q) begin
                       ph_n = PH_RLO; tx_n = rd_data[7:0]; drv_n = ~rd_data[7];
                     end else ph_n = PH_CMD;
            PH_CMD:  ph_n = PH_WLO;
            PH_WLO:  ph_n = PH_WHI;
            PH_RLO:  if (!mnack) begin
                       ph_n = PH_RHI; tx_n = rd_data[15:8]; drv_n = ~rd_data[15];
                     end else ph_n = PH_SKIP;
            default: ph_n = PH_SKIP;
          endcase
        end else if (bitcnt == 4'd8) begin
          ack_n = 1'b1; drv_n = 1'b1;
          case (ph)
            PH_ADDR: if (shreg[7:1] != DEV_ADDR) begin
                       ph_n = PH_SKIP; ack_n = 1'b0; drv_n = 1'b0;
                     end else rw_n = shreg[0];
            PH_CMD:  cmd_n = shreg;
            PH_WLO:  lo_n  = shreg;
            PH_WHI:  wr_en = 1'b1;
            default: drv_n = 1'b0;
          endcase
        end else if (reading) begin
          drv_n = ~txsr[6];
          tx_n  = {txsr[6:0], 1'b0};
        end
      end
    end
  end

  assign wr_data = {shreg, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; in_ack <= 1'b0; rw_q <= 1'b0; mnack <= 1'b1;
      bitcnt <= '0; shreg <= '0; txsr <= '0; lo_q <= '0; cmd <= '0;
      sda_oe <= 1'b0;
    end else begin
      ph <= ph_n; in_ack <= ack_n; rw_q <= rw_n; mnack <= nack_n;
      bitcnt <= bc_n; shreg <= sh_n; txsr <= tx_n; lo_q <= lo_n; cmd <= cmd_n;
      sda_oe <= drv_n;
    end
  end

  // R2
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
endmodule

// File: rtl/smbc_regs.sv
module smbc_regs
  import smbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  cmd,
  input  logic [15:0] wr_data,
  input  logic        wd_clear,
  output logic [15:0] rd_data,
  output logic        refresh,
  output logic [15:0] opt_q,
  output logic [15:0] ichg_q,
  output logic [15:0] vmax_q,
  output logic [15:0] vmin_q,
  output logic [15:0] iin_q
);
  logic [15:0] opt_n, ichg_n, vmax_n, vmin_n, iin_n;

  always_comb begin
    opt_n = opt_q; ichg_n = ichg_q; vmax_n = vmax_q; vmin_n = vmin_q; iin_n = iin_q;
    if (wd_clear) ichg_n = '0;
    if (wr_en) begin
      case (cmd)
        CMD_OPT:  opt_n  = wr_data;
        CMD_ICHG: ichg_n = wr_data;
        CMD_VMAX: vmax_n = wr_data;
        CMD_VMIN: vmin_n = wr_data;
        CMD_IIN:  iin_n  = wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (cmd)
      CMD_OPT:  rd_data = opt_q;
      CMD_ICHG: rd_data = ichg_q;
      CMD_VMAX: rd_data = vmax_q;
      CMD_VMIN: rd_data = vmin_q;
      CMD_IIN:  rd_data = iin_q;
      default:  rd_data = '0;
    endcase
  end

  assign refresh = wr_en && ((cmd == CMD_ICHG) || (cmd == CMD_VMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= RST_OPT; ichg_q <= RST_ICHG; vmax_q <= RST_VMAX;
      vmin_q <= RST_VMIN; iin_q <= RST_IIN;
    end else begin
      opt_q <= opt_n; ichg_q <= ichg_n; vmax_q <= vmax_n;
      vmin_q <= vmin_n; iin_q <= iin_n;
    end
  end
endmodule

// File: rtl/smbc_wdog.sv
module smbc_wdog #(
  parameter int UNIT_MS = 44000,
  parameter int DEG_MS  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       refresh,
  input  logic [1:0] sel,
  output logic       expire_p,
  output logic       expired
);
  localparam int LIM_MAX = 4 * UNIT_MS + DEG_MS;
  localparam int CW = $clog2(LIM_MAX + 1);
  localparam logic [CW-1:0] LIM1 = CW'(UNIT_MS + DEG_MS);
  localparam logic [CW-1:0] LIM2 = CW'(2 * UNIT_MS + DEG_MS);
  localparam logic [CW-1:0] LIM3 = CW'(LIM_MAX);

  logic [CW-1:0] cnt, cnt_n, limit;
  logic exp_n;

  always_comb begin
    case (sel)
      2'b01:   limit = LIM1;
      2'b10:   limit = LIM2;
      default: limit = LIM3;
    endcase
  end

  always_comb begin
    cnt_n = cnt; exp_n = expired; expire_p = 1'b0;
    if (sel == 2'b00 || refresh) begin
      cnt_n = '0; exp_n = 1'b0;
    end else if (tick && !expired) begin
      if (cnt + 1'b1 >= limit) begin
        expire_p = 1'b1; exp_n = 1'b1; cnt_n = '0;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; expired <= 1'b0;
    end else begin
      cnt <= cnt_n; expired <= exp_n;
    end
  end

  // R10
  wd_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expired) |-> ($past(refresh) || $past(sel) == 2'b00));
  // R8 R11
  wd_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> ($past(tick) && $past(sel) != 2'b00));
endmodule

// File: rtl/smbc_charger_regs.sv
module smbc_charger_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h09,
  parameter int         SYNC_STAGES = 2,
  parameter int         BUS_TOUT_MS = 30,
  parameter int         WD_UNIT_MS  = 44000,
  parameter int         WD_DEG_MS   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1ms,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [15:0] opt_o,
  output logic [15:0] chg_cur_o,
  output logic [15:0] chg_volt_o,
  output logic [15:0] min_sys_o,
  output logic [15:0] in_cur_o,
  output logic        charge_en_o,
  output logic        wd_expired_o
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p, tout_p;
  logic wr_en, refresh, wd_exp_p;
  logic [7:0] cmd;
  logic [15:0] wr_data, rd_data;

  smbc_busif #(.SYNC_STAGES(SYNC_STAGES), .TOUT_MS(BUS_TOUT_MS)) u_busif (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .tout_p(tout_p));

  smbc_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .tout_p(tout_p), .sda_s(sda_s),
    .rd_data(rd_data), .cmd(cmd), .wr_en(wr_en), .wr_data(wr_data),
    .sda_oe(sda_oe_o));

  smbc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(cmd), .wr_data(wr_data),
    .wd_clear(wd_exp_p), .rd_data(rd_data), .refresh(refresh),
    .opt_q(opt_o), .ichg_q(chg_cur_o), .vmax_q(chg_volt_o),
    .vmin_q(min_sys_o), .iin_q(in_cur_o));

  smbc_wdog #(.UNIT_MS(WD_UNIT_MS), .DEG_MS(WD_DEG_MS)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .refresh(refresh),
    .sel(opt_o[14:13]), .expire_p(wd_exp_p), .expired(wd_expired_o));

  assign charge_en_o = (chg_cur_o != 16'h0000) && !wd_expired_o;

  // R7
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout_p |=> !sda_oe_o);
  // R9
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_exp_p && !wr_en) |=> (chg_cur_o == 16'h0000 && wd_expired_o));
endmodule

// File: tb/smbc_charger_regs_bench.sv
module smbc_charger_regs_bench;
  localparam int HALF = 10;
  localparam logic [6:0] ADDR = 7'h09;

  logic clk = 1'b0;
  logic rst_n, tick, scl_m, sda_m;
  logic sda_oe;
  logic [15:0] opt, ichg, vmax, vmin, iin;
  logic chg_en, wd_exp;
  wire sda_line = sda_m & ~sda_oe;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  smbc_charger_regs #(.BUS_TOUT_MS(6), .WD_UNIT_MS(8), .WD_DEG_MS(2)) u_smbc_charger_regs (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .opt_o(opt), .chg_cur_o(ichg), .chg_volt_o(vmax),
    .min_sys_o(vmin), .in_cur_o(iin), .charge_en_o(chg_en), .wd_expired_o(wd_exp));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    w(2);
  endtask

  task automatic bstart();
    sda_m = 1'b1; w(HALF); scl_m = 1'b1; w(HALF);
    sda_m = 1'b0; w(HALF); scl_m = 1'b0; w(3);
  endtask

  task automatic bstop();
    sda_m = 1'b0; w(HALF); scl_m = 1'b1; w(HALF); sda_m = 1'b1; w(HALF);
  endtask

  task automatic bbit(input logic b, output logic s);
    sda_m = b; w(HALF); scl_m = 1'b1; w(HALF);
    s = sda_line; scl_m = 1'b0; w(3);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(b[i], s);
    bbit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bbit(1'b1, s);
      b[i] = s;
    end
    bbit(~mack, s);
  endtask

  task automatic wr_word(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d,
                         output logic [3:0] acks);
    bstart();
    sbyte({a, 1'b0}, acks[0]);
    sbyte(c, acks[1]);
    sbyte(d[7:0], acks[2]);
    sbyte(d[15:8], acks[3]);
    bstop();
  endtask

  task automatic rd_word(input logic [7:0] c, output logic [15:0] d);
    logic a;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(c, a);
    bstart(); sbyte({ADDR, 1'b1}, a);
    rbyte(1'b1, d[7:0]);
    rbyte(1'b0, d[15:8]);
    bstop();
  endtask

  task automatic t_reset();
    chk("R1 opt", opt, 32'h6140);
    chk("R1 ichg", ichg, 32'h0);
    chk("R1 vmax", vmax, 32'h34C0);
    chk("R1 vmin", vmin, 32'h2400);
    chk("R1 iin", iin, 32'h1000);
    chk("R1 sda", sda_oe, 32'h0);
    chk("R1 en", chg_en, 32'h0);
    chk("R1 wd", wd_exp, 32'h0);
  endtask

  task automatic t_write_read();
    logic [3:0] ak; logic [15:0] d;
    wr_word(ADDR, 8'h14, 16'h0800, ak);
    chk("R2 acks", ak, 32'hF);
    chk("R2 ichg", ichg, 32'h0800);
    chk("R12 en on", chg_en, 32'h1);
    rd_word(8'h14, d);
    chk("R3 read ichg", d, 32'h0800);
    wr_word(ADDR, 8'h3F, 16'h0A00, ak);
    rd_word(8'h3F, d);
    chk("R2 R3 iin", {iin, d}, 32'h0A000A00);
    wr_word(ADDR, 8'h3E, 16'h1800, ak);
    chk("R2 vmin", vmin, 32'h1800);
  endtask

  task automatic t_option();
    logic [3:0] ak; logic [15:0] d;
    wr_word(ADDR, 8'h12, 16'h6240, ak);
    rd_word(8'h12, d);
    chk("R6 opt readback", d, 32'h6240);
    chk("R6 freq field", opt[9:8], 32'h2);
    wr_word(ADDR, 8'h12, 16'h6140, ak);
    chk("R6 restore", opt, 32'h6140);
  endtask

  task automatic t_bad_addr();
    logic [3:0] ak;
    wr_word(7'h0A, 8'h14, 16'h1111, ak);
    chk("R4 addr nack", ak[0], 32'h0);
    chk("R4 ichg kept", ichg, 32'h0800);
  endtask

  task automatic t_unknown();
    logic [3:0] ak; logic [15:0] d;
    wr_word(ADDR, 8'h20, 16'hBEEF, ak);
    chk("R5 acks", ak, 32'hF);
    chk("R5 regs kept", {opt, ichg}, 32'h61400800);
    rd_word(8'h20, d);
    chk("R5 read zero", d, 32'h0);
  endtask

  task automatic t_read_nack();
    logic a; logic [7:0] b;
    bstart(); sbyte({ADDR, 1'b0}, a); sbyte(8'h14, a);
    bstart(); sbyte({ADDR, 1'b1}, a);
    rbyte(1'b0, b);
    chk("R3 low byte", b, 32'h00);
    rbyte(1'b0, b);
    chk("R3 released after nack", b, 32'hFF);
    bstop();
    chk("R3 sda idle", sda_oe, 32'h0);
  endtask

  task automatic t_timeout();
    logic s; logic [3:0] ak; logic [15:0] d;
    bstart();
    for (int i = 7; i >= 0; i--) bbit(ADDR_W(i), s);
    w(5);
    chk("R7 acking", sda_oe, 32'h1);
    ticks(5);
    chk("R7 still held", sda_oe, 32'h1);
    ticks(1);
    chk("R7 released", sda_oe, 32'h0);
    sda_m = 1'b1; w(HALF); scl_m = 1'b1; w(HALF);
    wr_word(ADDR, 8'h14, 16'h0C00, ak);
    rd_word(8'h14, d);
    chk("R7 recovers", {ak, d}, 32'hF0C00);
  endtask

  function automatic logic ADDR_W(input int i);
    logic [7:0] v = {ADDR, 1'b0};
    return v[i];
  endfunction

  task automatic t_wd_short();
    logic [3:0] ak; logic [15:0] d;
    wr_word(ADDR, 8'h12, 16'h2140, ak);
    wr_word(ADDR, 8'h14, 16'h0400, ak);
    ticks(9);
    chk("R8 sel01 before", {wd_exp, ichg}, 32'h00400);
    ticks(1);
    chk("R8 sel01 expired", wd_exp, 32'h1);
    chk("R9 ichg cleared", ichg, 32'h0);
    chk("R9 R12 en off", chg_en, 32'h0);
    rd_word(8'h14, d);
    chk("R9 read zero", d, 32'h0);
    wr_word(ADDR, 8'h15, 16'h3130, ak);
    chk("R10 vmax clears", wd_exp, 32'h0);
    wr_word(ADDR, 8'h14, 16'h0400, ak);
    ticks(5);
    wr_word(ADDR, 8'h3E, 16'h2400, ak);
    ticks(4);
    chk("R10 other write no restart", wd_exp, 32'h0);
    ticks(1);
    chk("R10 expiry kept count", wd_exp, 32'h1);
    wr_word(ADDR, 8'h14, 16'h0400, ak);
    ticks(7);
    wr_word(ADDR, 8'h15, 16'h3130, ak);
    ticks(7);
    chk("R10 vmax restarts", {wd_exp, chg_en}, 32'h1);
    ticks(3);
    chk("R10 after restart", wd_exp, 32'h1);
  endtask

  task automatic t_wd_long();
    logic [3:0] ak;
    wr_word(ADDR, 8'h12, 16'h4140, ak);
    wr_word(ADDR, 8'h14, 16'h0400, ak);
    ticks(17);
    chk("R8 sel10 before", wd_exp, 32'h0);
    ticks(1);
    chk("R8 sel10 expired", wd_exp, 32'h1);
    wr_word(ADDR, 8'h12, 16'h6140, ak);
    wr_word(ADDR, 8'h14, 16'h0400, ak);
    ticks(33);
    chk("R8 sel11 before", wd_exp, 32'h0);
    ticks(1);
    chk("R8 sel11 expired", wd_exp, 32'h1);
    wr_word(ADDR, 8'h12, 16'h0140, ak);
    wr_word(ADDR, 8'h14, 16'h0400, ak);
    ticks(40);
    chk("R11 disabled", {wd_exp, ichg}, 32'h00400);
    chk("R11 R12 en", chg_en, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL all watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    w(5);
    rst_n = 1'b1;
    w(5);
    t_reset();
    t_write_read();
    t_option();
    t_bad_addr();
    t_unknown();
    t_read_nack();
    t_timeout();
    t_wd_short();
    t_wd_long();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule